// File: doc/BRIEF.md
# Cascaded Half-Band Interpolator

This block raises the sample rate of a real signed data stream bound for a digital-to-analog converter by 1, 2, 4 or 8. Up to three identical 2x stages are chained, and a 2-bit rate field selects how many of them are active. Each stage conceptually puts one zero after every sample it receives and removes the resulting spectral image with a 7-tap half-band low-pass filter. The zero-valued samples contribute nothing, so the stage computes its two output phases directly. One phase is a copy of the delayed centre sample. The other is a four-tap symmetric sum. The filter gain is doubled to restore the amplitude lost to zero stuffing. The passband of each stage covers roughly 0.4 times its input rate.

The block runs on one clock at the output sample rate and delivers one sample on every clock. Input samples are taken over a ready/valid handshake once every F clocks, where F is the selected factor. An upstream source therefore works at the slow data rate while the output runs at the full rate. The factor is captured only while reset is held, and reset clears every delay line.

Top module: `hbi_interp_top`

## Requirements
- R1: The field `rate_sel` selects the number of active stages N: 0 gives factor 1, 1 gives 2, 2 gives 4 and 3 gives 8, with F = 2^N. The field is sampled only while `rst` is high, and any change while `rst` is low has no effect on the outputs.
- R2: Cycle t = 0 is the first clock after `rst` falls. For F >= 2, `in_ready` is high exactly in the cycles where t mod F equals F/2. For F = 1 it is high in every cycle.
- R3: In cycle t, `out_data` is 0 for t < F and equals element t - F of the ideal cascade output for t >= F. The cascade starts from all-zero state and is fed the accepted input sequence.
- R4: For each input x[i], a 2x stage emits two samples in order: first A_i = round((9*x[i-1] + 9*x[i-2] - x[i] - x[i-3]) / 16), then B_i = x[i-1]. Samples before the first accepted input count as zero.
- R5: Rounding adds 8 to the tap sum and then takes the floor of the division by 16. The result saturates to the signed `DW`-bit range [-2^(DW-1), 2^(DW-1)-1].
- R6: Factor 4 is exactly two stages of R4 in series, and factor 8 is exactly three.
- R7: If `in_valid` is low in a cycle where `in_ready` is high, the block takes a zero sample for that slot. The slot timing is unchanged and the following samples keep their positions.
- R8: While `rst` is high and in the first cycle after it falls, `out_data` is 0. All delay lines start from zero after every reset.
- R9: With factor 1, `out_data` equals the `in_data` of the previous cycle when `in_valid` was high, and 0 when it was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset; also the window in which the factor is loaded |
| rate_sel | input | 2 | Number of active 2x stages (0..3) |
| in_valid | input | 1 | Input sample present |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Input sample taken this cycle |
| out_data | output | 16 | Signed output sample, one per clock |

## Verification
The bench builds the block with its default parameters: 16-bit samples and three stages. This makes all four factors reachable, and full-scale inputs can push the odd-phase sum past the sample range, which exercises saturation. A behavioural model expands queues of integers through repeated 2x steps and is compared with `out_data` and `in_ready` on every clock. Stimulus covers ramps, an impulse that exposes the exact tap weights, extreme alternating values, dropped input slots, and a change of `rate_sel` outside reset.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // half-band taps, scaled so the stage gain of 2 is folded in (divide by 2^HB_SHIFT)
  localparam int HB_NEAR      = 9;
  localparam int HB_FAR       = 1;
  localparam int HB_SHIFT     = 4;
  // accumulator headroom above the sample width
  localparam int HB_GAIN_BITS = 5;
endpackage

// File: rtl/hbi_slot_timer.sv
module hbi_slot_timer #(
  parameter int MAX_STG = 3,
  localparam int SW = $clog2(MAX_STG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] nstg,
  output logic          stg_tick [MAX_STG],
  output logic          stg_take [MAX_STG],
  output logic          in_ready
);
  localparam int CW = (MAX_STG < 1) ? 1 : MAX_STG;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wrap_mask;

  always_comb begin
    for (int b = 0; b < CW; b++) wrap_mask[b] = (b < int'(nstg));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= (cnt_q + CW'(1)) & wrap_mask;
  end

  // stage j ticks every 2^k cycles (k = N-1-j) and takes input when bit k is set
  for (genvar j = 0; j < MAX_STG; j++) begin : g_stg
    always_comb begin
      int   k;
      logic low_zero;
      logic phase;
      k        = int'(nstg) - 1 - j;
      low_zero = 1'b1;
      phase    = 1'b0;
      for (int b = 0; b < CW; b++) begin
        if (b < k && cnt_q[b]) low_zero = 1'b0;
        if (b == k)            phase    = cnt_q[b];
      end
      stg_tick[j] = (j < int'(nstg)) && low_zero;
      stg_take[j] = stg_tick[j] && phase;
    end
  end

  assign in_ready = (nstg == '0) ? 1'b1 : stg_take[0];

  AST_READY_SPACING: assert property (@(posedge clk) disable iff (rst)
    (in_ready && nstg != '0) |=> !in_ready); // R2
endmodule

// File: rtl/hbi_half_band_x2.sv
module hbi_half_band_x2 import hbi_pkg::*; #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 take,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] y_out
);
  localparam int AW = DW + HB_GAIN_BITS;
  localparam logic signed [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

  // odd phase: symmetric taps on x[i-1], x[i-2] and x[i], x[i-3]; round, then saturate
  function automatic logic signed [DW-1:0] odd_phase(
    input logic signed [DW-1:0] xn, xn1, xn2, xn3);
    logic signed [AW-1:0] sum_v;
    logic signed [AW-1:0] rnd_v;
    sum_v = AW'(HB_NEAR) * (AW'(xn1) + AW'(xn2)) - AW'(HB_FAR) * (AW'(xn) + AW'(xn3));
    rnd_v = (sum_v + AW'(1 <<< (HB_SHIFT - 1))) >>> HB_SHIFT;
    if (rnd_v > AW'(S_MAX)) return S_MAX;
    if (rnd_v < AW'(S_MIN)) return S_MIN;
    return rnd_v[DW-1:0];
  endfunction

  logic signed [DW-1:0] dly_q [3];
  logic signed [DW-1:0] y_q;
  logic                 emit_centre;

  assign emit_centre = tick && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) dly_q[i] <= '0;
      y_q <= '0;
    end else if (take) begin
      dly_q[0] <= x_in;
      dly_q[1] <= dly_q[0];
      dly_q[2] <= dly_q[1];
      y_q      <= odd_phase(x_in, dly_q[0], dly_q[1], dly_q[2]);
    end else if (emit_centre) begin
      y_q <= dly_q[1];
    end
  end

  assign y_out = y_q;

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (take && x_in == '0 && dly_q[0] == '0 && dly_q[1] == '0 && dly_q[2] == '0)
      |=> y_q == '0); // R4
  AST_TAKE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    take |=> !take); // R4
endmodule

// File: rtl/hbi_interp_top.sv
module hbi_interp_top #(
  parameter int DW = 16,
  parameter int MAX_STG = 3,
  localparam int SW = $clog2(MAX_STG + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        rate_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  output logic signed [DW-1:0] out_data
);
  logic [SW-1:0]        nstg_q;
  logic signed [DW-1:0] byp_q;
  logic signed [DW-1:0] src_smp;
  logic signed [DW-1:0] stg_y [MAX_STG];
  logic                 stg_tick [MAX_STG];
  logic                 stg_take [MAX_STG];

  // factor is loaded only in reset
  always_ff @(posedge clk) begin
    if (rst) nstg_q <= rate_sel;
  end

  assign src_smp = in_valid ? in_data : '0;

  always_ff @(posedge clk) begin
    if (rst) byp_q <= '0;
    else     byp_q <= src_smp;
  end

  hbi_slot_timer #(.MAX_STG(MAX_STG)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .nstg     (nstg_q),
    .stg_tick (stg_tick),
    .stg_take (stg_take),
    .in_ready (in_ready)
  );

  for (genvar j = 0; j < MAX_STG; j++) begin : g_chain
    logic signed [DW-1:0] x_feed;
    if (j == 0) begin : g_head
      assign x_feed = src_smp;
    end else begin : g_link
      assign x_feed = stg_y[j-1];
    end
    hbi_half_band_x2 #(.DW(DW)) i_stage (
      .clk   (clk),
      .rst   (rst),
      .tick  (stg_tick[j]),
      .take  (stg_take[j]),
      .x_in  (x_feed),
      .y_out (stg_y[j])
    );
  end

  always_comb begin
    out_data = byp_q;
    for (int j = 0; j < MAX_STG; j++)
      if (j == int'(nstg_q) - 1) out_data = stg_y[j];
  end

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(nstg_q)); // R1
  AST_OUT_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_data == '0); // R8
  AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (rst)
    (nstg_q == '0 && !$past(rst))
      |-> out_data == ($past(in_valid) ? $past(in_data) : '0)); // R9
endmodule

// File: tb/test_hbi_interp_top.sv
module test_hbi_interp_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [1:0]           rate_sel = 2'd0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 in_ready;
  logic signed [DW-1:0] out_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbi_interp_top i_hbi_interp_top (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_data(out_data)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int floor_div16(input int s);
    int q;
    q = s / 16;
    if (s < 0 && (s % 16) != 0) q = q - 1;
    return q;
  endfunction

  function automatic int clip(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // one 2x step: two outputs per input sample
  function automatic void up2(input int src[$], output int dst[$]);
    dst = {};
    foreach (src[i]) begin
      int p1, p2, p3, s;
      p1 = (i >= 1) ? src[i-1] : 0;
      p2 = (i >= 2) ? src[i-2] : 0;
      p3 = (i >= 3) ? src[i-3] : 0;
      s  = 9 * p1 + 9 * p2 - src[i] - p3;
      dst.push_back(clip(floor_div16(s + 8)));
      dst.push_back(p1);
    end
  endfunction

  function automatic int stim(input int kind, input int i);
    case (kind)
      0: return ((i * 2731 + 77) % 20000) - 10000;
      1: begin
        int v;
        v = ((i % 3) == 0) ? -32768 : 32767;
        return ((i / 3) % 2 == 0) ? v : ((v == 32767) ? -32768 : 32767);
      end
      default: return (i == 1) ? 1000 : 0;
    endcase
  endfunction

  task automatic run_case(input int nsel, input int ncyc, input int kind,
                          input int drop_every, input bit swap_sel, input string tag);
    int f, nin, idx;
    int xs[$];
    int mdl[$];
    int tmp[$];
    f   = 1 << nsel;
    nin = ncyc / f + 4;
    for (int i = 0; i < nin; i++) xs.push_back(stim(kind, i));
    for (int i = 0; i < nin; i++)
      mdl.push_back((drop_every > 0 && (i % drop_every) == drop_every - 1) ? 0 : xs[i]);
    for (int s = 0; s < nsel; s++) begin
      up2(mdl, tmp);
      mdl = tmp;
    end
    @(negedge clk);
    rst = 1'b1; rate_sel = 2'(nsel); in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check(int'(out_data), 0, {tag, " R8 reset output"});
    rst = 1'b0;
    idx = 0;
    for (int t = 0; t < ncyc; t++) begin
      bit exp_rdy;
      exp_rdy  = (f == 1) || ((t % f) == f / 2);
      in_data  = 16'(xs[idx]);
      in_valid = !(drop_every > 0 && (idx % drop_every) == drop_every - 1);
      if (swap_sel && t == ncyc / 2) rate_sel = 2'(3 - nsel);
      #1;
      check(int'(in_ready), int'(exp_rdy), {tag, " R2 ready slot"});
      check(int'(out_data), (t < f) ? 0 : mdl[t - f], {tag, " R3 output sample"});
      @(posedge clk);
      if (exp_rdy) idx++;
      @(negedge clk);
    end
  endtask

  initial begin
    run_case(0,  64, 0, 0, 1'b0, "R9 bypass ramp");
    run_case(1, 200, 0, 0, 1'b0, "R4 x2 ramp");
    run_case(1,  64, 2, 0, 1'b0, "R4 x2 impulse");
    run_case(2, 200, 0, 0, 1'b0, "R6 x4 ramp");
    run_case(3, 256, 0, 0, 1'b0, "R6 x8 ramp");
    run_case(3, 256, 1, 0, 1'b0, "R5 x8 saturation");
    run_case(1, 120, 1, 0, 1'b0, "R5 x2 saturation");
    run_case(2, 200, 0, 5, 1'b0, "R7 x4 dropped slots");
    run_case(0,  64, 0, 3, 1'b0, "R7 bypass dropped slots");
    run_case(2, 240, 0, 0, 1'b1, "R1 select change outside reset");
    run_case(3, 128, 2, 0, 1'b0, "R8 x8 impulse after reset");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule